// File: doc/BRIEF.md
# Priority Bus Arbitration Agent

This block is the arbitration logic that sits inside each device on a shared bus with no central arbiter. The bus carries one request line per priority level (sixteen by default) and one busy line. Every device watches all of the request lines and the busy line, and knows its own level. When its device asks for the bus, the agent raises the request line of its own level. On each clock edge it checks whether any request above its own level is active and whether the bus is free. If the bus is free and no higher request is active, it takes the bus.

Taking the bus means three things happen in the same cycle: the agent drops its request line, raises busy and reports the grant to its device. It keeps the bus until its device signals completion, and it frees the busy line one clock after that. The wired lines are resolved by OR outside the block. All agents sample the resolved lines on the same clock edge. Because of this, two agents that request at the same time can never both win.

Top module: `prio_bus_agent`

## Requirements
- R1: While reset is high and in the first cycle after it, the agent drives no request line, keeps busy low and does not report a grant.
- R2: An agent that is neither requesting nor owning, with want_i high at a clock edge, drives its own request line (bit LEVEL of req_o, all other bits zero) from the next cycle.
- R3: A requesting agent whose want_i is still high takes the bus at a clock edge where busy_i is low and no line numbered above LEVEL is active. Line 15 is the highest priority and line 0 the lowest.
- R4: A requesting agent does not take the bus at an edge where any request line numbered above LEVEL is active. It keeps its own request up.
- R5: A requesting agent does not take the bus at an edge where busy_i is high.
- R6: In the cycle grant_o rises, req_o is all zero and busy_o is high.
- R7: An owner keeps grant_o and busy_o high until done_i is high at a clock edge. From the next cycle both are low.
- R8: A requesting agent that sees want_i low at a clock edge drops its request without taking the bus, even if it would have won at that edge.
- R9: Among agents that share the resolved lines and the clock, at most one reports a grant in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| want_i | input | 1 | The local device asks for the bus |
| done_i | input | 1 | The local device has finished with the bus |
| req_lines_i | input | NUM_LINES | OR-resolved request lines of all agents |
| busy_i | input | 1 | OR-resolved busy line of all agents |
| req_o | output | NUM_LINES | This agent's contribution to the request lines (only bit LEVEL ever set) |
| busy_o | output | 1 | This agent's contribution to the busy line |
| grant_o | output | 1 | This agent currently owns the bus |

## Verification
The bench connects sixteen agents through OR-resolved lines and targets the following cases. Simultaneous requests at levels 2, 9 and 15 must be served strictly top-down. A design that compared levels in the wrong direction, or that ignored higher lines, would grant level 2 first or grant several agents at once. A low-level request raised while another agent owns the bus must wait for the release. A design that ignored busy would grant it at once, and one that released busy late would hold it back an extra cycle. A request withdrawn while blocked must vanish without a grant. A long random run then compares the grant, request and busy lines on every cycle with a behavioural model, which exposes grants that start or end one cycle early or late.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

    typedef enum logic [1:0] {
        AG_IDLE = 2'd0,
        AG_WAIT = 2'd1,
        AG_OWN  = 2'd2
    } agent_state_e;

    typedef struct packed {
        logic want;
        logic done;
        logic bus_taken;
        logic outranked;
    } agent_view_t;

    function automatic logic may_take(input agent_view_t v);
        return v.want && !v.bus_taken && !v.outranked;
    endfunction

endpackage

// File: rtl/higher_detect.sv
module higher_detect #(
    parameter int NUM_LINES = 16,
    parameter int LEVEL     = 0
) (
    input  logic [NUM_LINES-1:0] lines_i,
    output logic                 outranked_o
);
    logic [NUM_LINES-1:0] above_mask;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_mask
        if (g > LEVEL) begin : g_above
            assign above_mask[g] = 1'b1;
        end else begin : g_below
            assign above_mask[g] = 1'b0;
        end
    end

    assign outranked_o = |(lines_i & above_mask);
endmodule

// File: rtl/agent_fsm.sv
module agent_fsm
    import bus_arb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  agent_view_t   view_i,
    output agent_state_e  state_o
);
    agent_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AG_IDLE: if (view_i.want) state_d = AG_WAIT;
            AG_WAIT: begin
                if (!view_i.want)          state_d = AG_IDLE;
                else if (may_take(view_i)) state_d = AG_OWN;
            end
            AG_OWN:  if (view_i.done) state_d = AG_IDLE;
            default: state_d = AG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= AG_IDLE;
        else     state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/line_driver.sv
module line_driver
    import bus_arb_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int LEVEL     = 0
) (
    input  agent_state_e         state_i,
    output logic [NUM_LINES-1:0] req_o,
    output logic                 busy_o,
    output logic                 grant_o
);
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        if (g == LEVEL) begin : g_own
            assign req_o[g] = (state_i == AG_WAIT);
        end else begin : g_other
            assign req_o[g] = 1'b0;
        end
    end

    assign busy_o  = (state_i == AG_OWN);
    assign grant_o = (state_i == AG_OWN);
endmodule

// File: rtl/prio_bus_agent.sv
module prio_bus_agent
    import bus_arb_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int LEVEL     = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 want_i,
    input  logic                 done_i,
    input  logic [NUM_LINES-1:0] req_lines_i,
    input  logic                 busy_i,
    output logic [NUM_LINES-1:0] req_o,
    output logic                 busy_o,
    output logic                 grant_o
);
    logic         outranked;
    agent_view_t  view;
    agent_state_e state;

    higher_detect #(.NUM_LINES(NUM_LINES), .LEVEL(LEVEL)) i_higher (
        .lines_i     (req_lines_i),
        .outranked_o (outranked)
    );

    assign view = '{want: want_i, done: done_i, bus_taken: busy_i, outranked: outranked};

    agent_fsm i_fsm (
        .clk     (clk),
        .rst     (rst),
        .view_i  (view),
        .state_o (state)
    );

    line_driver #(.NUM_LINES(NUM_LINES), .LEVEL(LEVEL)) i_drv (
        .state_i (state),
        .req_o   (req_o),
        .busy_o  (busy_o),
        .grant_o (grant_o)
    );

    // R2
    raise_own_line_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_o[LEVEL] && !grant_o && want_i) |=> req_o[LEVEL]);

    // R3
    win_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(grant_o) |-> $past(req_o[LEVEL] && want_i && !busy_i && !outranked));

    // R4
    outranked_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (req_o[LEVEL] && outranked) |=> !grant_o);

    // R5
    busy_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (req_o[LEVEL] && busy_i) |=> !grant_o);

    // R6
    drop_on_win_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(grant_o) |-> (req_o == '0 && busy_o));

    // R7
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_o && done_i) |=> (!busy_o && !grant_o));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_o && !done_i) |=> (grant_o && busy_o));

    // R8
    withdraw_chk: assert property (@(posedge clk) disable iff (rst)
        (req_o[LEVEL] && !want_i) |=> (req_o == '0 && !grant_o));
endmodule

// File: tb/test_prio_bus_agent.sv
`timescale 1ns/1ps
module test_prio_bus_agent;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] want = '0;
    logic [N-1:0] done = '0;
    logic [N-1:0] req_all [N];
    logic [N-1:0] busy_vec, grant_vec;
    logic [N-1:0] req_bus;
    logic         busy_bus;
    int           errors = 0, checks = 0;
    bit           finished = 0;
    int           m_st [N];

    always #2.5 clk = ~clk;

    for (genvar g = 0; g < N; g++) begin : g_agent
        if (g == 0) begin : g_top
            prio_bus_agent #(.NUM_LINES(N), .LEVEL(g)) i_prio_bus_agent (
                .clk(clk), .rst(rst), .want_i(want[g]), .done_i(done[g]),
                .req_lines_i(req_bus), .busy_i(busy_bus),
                .req_o(req_all[g]), .busy_o(busy_vec[g]), .grant_o(grant_vec[g]));
        end else begin : g_rest
            prio_bus_agent #(.NUM_LINES(N), .LEVEL(g)) i_agent (
                .clk(clk), .rst(rst), .want_i(want[g]), .done_i(done[g]),
                .req_lines_i(req_bus), .busy_i(busy_bus),
                .req_o(req_all[g]), .busy_o(busy_vec[g]), .grant_o(grant_vec[g]));
        end
    end

    always_comb begin
        req_bus = '0;
        for (int k = 0; k < N; k++) req_bus |= req_all[k];
    end
    assign busy_bus = |busy_vec;

    // Behavioural model: 0 idle, 1 requesting, 2 owning
    always @(posedge clk) begin
        int  snap [N];
        bit  taken;
        bit  above;
        for (int i = 0; i < N; i++) snap[i] = m_st[i];
        taken = 0;
        for (int i = 0; i < N; i++) if (snap[i] == 2) taken = 1;
        for (int i = 0; i < N; i++) begin
            if (rst) m_st[i] = 0;
            else if (snap[i] == 0) begin
                if (want[i]) m_st[i] = 1;
            end else if (snap[i] == 1) begin
                above = 0;
                for (int j = i + 1; j < N; j++) if (snap[j] == 1) above = 1;
                if (!want[i]) m_st[i] = 0;
                else if (!taken && !above) m_st[i] = 2;
            end else begin
                if (done[i]) m_st[i] = 0;
            end
        end
    end

    function automatic logic [N-1:0] exp_grant();
        logic [N-1:0] r = '0;
        for (int i = 0; i < N; i++) r[i] = (m_st[i] == 2);
        return r;
    endfunction

    function automatic logic [N-1:0] exp_req();
        logic [N-1:0] r = '0;
        for (int i = 0; i < N; i++) r[i] = (m_st[i] == 1);
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R3/R4/R5/R7 grant vs model", 32'(grant_vec), 32'(exp_grant()));
            check("R2/R6/R8 request lines vs model", 32'(req_bus), 32'(exp_req()));
            check("R7 busy vs model", 32'(busy_bus), 32'(|exp_grant()));
            check("R9 single owner", 32'($countones(grant_vec) <= 1), 32'd1);
        end
    end

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(4);
        check("R1 req during reset", 32'(req_bus), 32'd0);
        check("R1 busy during reset", 32'(busy_bus), 32'd0);
        rst = 1'b0;
        tick();
        check("R1 grant after reset", 32'(grant_vec), 32'd0);
        check("R1 req after reset", 32'(req_bus), 32'd0);

        // Single requester
        want[3] = 1'b1;
        tick();
        check("R2 own line only", 32'(req_bus), 32'h0008);
        check("R2 no grant yet", 32'(grant_vec), 32'd0);
        tick();
        check("R3 lone requester wins", 32'(grant_vec), 32'h0008);
        check("R6 request dropped", 32'(req_bus), 32'd0);
        check("R6 busy raised", 32'(busy_bus), 32'd1);
        want[3] = 1'b0;
        done[3] = 1'b1;
        tick();
        done[3] = 1'b0;
        check("R7 grant released", 32'(grant_vec), 32'd0);
        check("R7 busy released", 32'(busy_bus), 32'd0);

        // Three simultaneous requesters
        want = 16'h8204;
        tick();
        check("R2 three lines up", 32'(req_bus), 32'h8204);
        tick();
        check("R4 level 15 first", 32'(grant_vec), 32'h8000);
        check("R4 lower still requesting", 32'(req_bus), 32'h0204);
        want[15] = 1'b0;
        tick(3);
        check("R7 held without done", 32'(grant_vec), 32'h8000);
        done[15] = 1'b1;
        tick();
        done[15] = 1'b0;
        check("R7 gap after done", 32'(grant_vec), 32'd0);
        tick();
        check("R4 level 9 next", 32'(grant_vec), 32'h0200);
        want[9] = 1'b0;
        done[9] = 1'b1;
        tick();
        done[9] = 1'b0;
        tick();
        check("R3 level 2 last", 32'(grant_vec), 32'h0004);
        want[2] = 1'b0;
        done[2] = 1'b1;
        tick();
        done[2] = 1'b0;

        // Lower level waits while bus busy
        want[5] = 1'b1;
        tick(2);
        check("R3 level 5 owns", 32'(grant_vec), 32'h0020);
        want[5] = 1'b0;
        want[1] = 1'b1;
        tick(4);
        check("R5 level 1 blocked by busy", 32'(grant_vec), 32'h0020);
        check("R5 level 1 still requesting", 32'(req_bus), 32'h0002);
        done[5] = 1'b1;
        tick();
        done[5] = 1'b0;
        check("R5 no grant in release cycle", 32'(grant_vec), 32'd0);
        tick();
        check("R5 level 1 after release", 32'(grant_vec), 32'h0002);
        want[1] = 1'b0;
        done[1] = 1'b1;
        tick();
        done[1] = 1'b0;

        // Withdrawal while blocked
        want[7] = 1'b1;
        tick(2);
        want[7] = 1'b0;
        want[4] = 1'b1;
        tick();
        check("R8 level 4 requesting", 32'(req_bus), 32'h0010);
        want[4] = 1'b0;
        done[7] = 1'b1;
        tick();
        done[7] = 1'b0;
        check("R8 request withdrawn", 32'(req_bus), 32'd0);
        tick(2);
        check("R8 no grant after withdraw", 32'(grant_vec), 32'd0);

        // Random traffic
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < N; i++) begin
                if ($urandom_range(0, 7) == 0) want[i] = ~want[i];
                done[i] = ($urandom_range(0, 3) == 0);
            end
            tick();
        end
        want = '0;
        done = '1;
        tick(3);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule